// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This combinational unit works on fields inside a data word. A field is a contiguous run of bits, given at run time by the position of its lowest bit and by its bit count. In the two extract modes the unit returns the field right-justified. The bits above the field are filled with zeros for unsigned extract, or with copies of the field's top bit for signed extract. In insert mode the unit returns the word with that field replaced by the low bits of a second operand, and every bit outside the field keeps its value.

Extraction is done by a shift pair. A left shift moves the field's top bit to the word's top bit, and a right shift then brings the field down to bit 0. That right shift is logical, or arithmetic for the signed variant. Insertion clears the field with a full-width mask, shifts the trimmed value up to the field's position, and merges the two with OR. A field that does not fit in the word raises an error flag, and the word then passes through unchanged. The unit is meant to sit in a datapath next to an ALU, fed by decoded field descriptors.

Top module: `bfu_field_unit`

## Requirements
- R1: With mode_i = 0 (unsigned extract), result_o holds word bits [lsb_i+width_i-1 : lsb_i] in bits [width_i-1:0], and every higher bit is 0.
- R2: With mode_i = 1 (signed extract), result_o holds the same field in bits [width_i-1:0], and every higher bit equals field bit width_i-1. For example, a 16-bit field at lsb 0 holding 0xFFFC gives 0xFFFFFFFC.
- R3: With mode_i = 2 (insert), result_o equals word_i, except that bits [lsb_i+width_i-1 : lsb_i] hold value_i[width_i-1:0].
- R4: In insert mode, bits of value_i at positions width_i and above have no effect on result_o.
- R5: The clearing mask affects only the field bits, including the upper half of the word. For example, inserting 0 into bits 9..2 of 0xFFFFFFFF gives 0xFFFFFC03.
- R6: err_o is 1 when width_i is 0, or when width_i is greater than 32, or when lsb_i + width_i is greater than 32. In every mode, result_o then equals word_i.
- R7: A full-width field (lsb_i = 0, width_i = 32) is legal. Extract then returns word_i, and insert returns value_i.
- R8: mode_i = 3 returns word_i unchanged. err_o still follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 32 | Source word |
| value_i | input | 32 | Value whose low bits are inserted |
| lsb_i | input | 5 | Position of the field's lowest bit |
| width_i | input | 6 | Field bit count, legal range 1..32 |
| mode_i | input | 2 | 0 unsigned extract, 1 signed extract, 2 insert, 3 pass-through |
| result_o | output | 32 | Extracted field or modified word |
| err_o | output | 1 | Field descriptor out of range |

## Verification
Immediate assertions inside the design check every evaluation for four properties. In insert mode, the result differs from the word only inside the mask. The mask holds exactly width_i ones. Unsigned extracts are zero above the field, and signed extracts repeat the field's top bit above the field. An error forces pass-through. Whether the field lands in the right place can only be shown by the bench, which compares against an expected value built bit by bit, for random and directed descriptors. The same holds for the exact mask in the 9..2 example, the dropping of high value bits, and the full-width boundary.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [1:0] {
      BFU_XTR_U = 2'd0,
      BFU_XTR_S = 2'd1,
      BFU_INS   = 2'd2,
      BFU_PASS  = 2'd3
   } bfu_mode_e;
endpackage

// File: rtl/bfu_range_chk.sv
module bfu_range_chk #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W),
   localparam int LEN_W = POS_W + 1
) (
   input  logic [POS_W-1:0] lsb_i,
   input  logic [LEN_W-1:0] width_i,
   output logic             bad_o
);
   localparam int SUM_W = LEN_W + 1;
   localparam logic [SUM_W-1:0] DW = SUM_W'(DATA_W);

   logic [SUM_W-1:0] reach;

   always_comb begin
      reach = SUM_W'(lsb_i) + SUM_W'(width_i);
      bad_o = (width_i == '0) || (SUM_W'(width_i) > DW) || (reach > DW);
   end

   always_comb begin
      if (!$isunknown({lsb_i, width_i})) begin
         // R6
         zero_width_flag_chk: assert (width_i != '0 || bad_o)
            else $error("zero width not flagged");
      end
   end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
   parameter int DATA_W    = 32,
   parameter bit SIGNED_EN = 1'b1,
   localparam int POS_W = $clog2(DATA_W),
   localparam int LEN_W = POS_W + 1
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [POS_W-1:0]  lsb_i,
   input  logic [LEN_W-1:0]  width_i,
   input  logic              sext_i,
   input  logic              ok_i,
   output logic [DATA_W-1:0] field_o
);
   localparam int SH_W = LEN_W + 1;
   localparam logic [SH_W-1:0] DW = SH_W'(DATA_W);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [SH_W-1:0]   up_sh;
   logic [SH_W-1:0]   dn_sh;
   logic [DATA_W-1:0] lifted;
   logic [DATA_W-1:0] zfill;
   logic [DATA_W-1:0] sfill;

   always_comb begin
      up_sh  = DW - SH_W'(lsb_i) - SH_W'(width_i);
      dn_sh  = DW - SH_W'(width_i);
      lifted = word_i << up_sh;
      zfill  = lifted >> dn_sh;
   end

   generate
      if (SIGNED_EN) begin : g_sext
         always_comb sfill = DATA_W'($signed(lifted) >>> dn_sh);
      end else begin : g_nosext
         always_comb sfill = zfill;
      end
   endgenerate

   assign field_o = sext_i ? sfill : zfill;

   always_comb begin
      if (ok_i && !$isunknown({word_i, lsb_i, width_i, sext_i})) begin
         // R1
         if (!sext_i) begin
            zero_above_field_chk: assert ((field_o >> width_i) == '0)
               else $error("unsigned extract has bits above field");
         end
         // R2
         if (sext_i && SIGNED_EN) begin
            sign_fill_chk: assert (((field_o >> (width_i - 1'b1)) == '0) ||
                                   ((field_o >> (width_i - 1'b1)) == (ONES >> (width_i - 1'b1))))
               else $error("signed extract fill mismatch");
         end
      end
   end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W),
   localparam int LEN_W = POS_W + 1
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [DATA_W-1:0] value_i,
   input  logic [POS_W-1:0]  lsb_i,
   input  logic [LEN_W-1:0]  width_i,
   input  logic              ok_i,
   output logic [DATA_W-1:0] merged_o
);
   localparam int SH_W = LEN_W + 1;
   localparam logic [SH_W-1:0] DW = SH_W'(DATA_W);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] hole_mask;
   logic [DATA_W-1:0] cleared;
   logic [DATA_W-1:0] placed;

   always_comb begin
      low_mask  = ONES >> (DW - SH_W'(width_i));
      hole_mask = low_mask << lsb_i;
      cleared   = word_i & ~hole_mask;
      placed    = (value_i & low_mask) << lsb_i;
      merged_o  = cleared | placed;
   end

   always_comb begin
      if (ok_i && !$isunknown({word_i, value_i, lsb_i, width_i})) begin
         // R3
         outside_kept_chk: assert (((merged_o ^ word_i) & ~hole_mask) == '0)
            else $error("insert touched bits outside field");
         // R5
         mask_size_chk: assert ($countones(hole_mask) == int'(width_i))
            else $error("clearing mask size wrong");
      end
   end
endmodule

// File: rtl/bfu_field_unit.sv
module bfu_field_unit #(
   parameter int DATA_W    = 32,
   parameter bit SIGNED_EN = 1'b1,
   localparam int POS_W = $clog2(DATA_W),
   localparam int LEN_W = POS_W + 1
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [DATA_W-1:0] value_i,
   input  logic [POS_W-1:0]  lsb_i,
   input  logic [LEN_W-1:0]  width_i,
   input  logic [1:0]        mode_i,
   output logic [DATA_W-1:0] result_o,
   output logic              err_o
);
   import bfu_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if ((1 << POS_W) != DATA_W) begin : g_bad_pow
         $error("DATA_W must be a power of two");
      end
   endgenerate

   logic              bad;
   logic [DATA_W-1:0] xtr;
   logic [DATA_W-1:0] ins;
   bfu_mode_e         mode;

   assign mode = bfu_mode_e'(mode_i);

   bfu_range_chk #(.DATA_W(DATA_W)) u_rng (
      .lsb_i   (lsb_i),
      .width_i (width_i),
      .bad_o   (bad)
   );

   bfu_extract #(.DATA_W(DATA_W), .SIGNED_EN(SIGNED_EN)) u_xtr (
      .word_i  (word_i),
      .lsb_i   (lsb_i),
      .width_i (width_i),
      .sext_i  (mode == BFU_XTR_S),
      .ok_i    (!bad),
      .field_o (xtr)
   );

   bfu_insert #(.DATA_W(DATA_W)) u_ins (
      .word_i   (word_i),
      .value_i  (value_i),
      .lsb_i    (lsb_i),
      .width_i  (width_i),
      .ok_i     (!bad),
      .merged_o (ins)
   );

   always_comb begin
      err_o = bad;
      if (bad) begin
         result_o = word_i;
      end else begin
         unique case (mode)
            BFU_XTR_U, BFU_XTR_S: result_o = xtr;
            BFU_INS:              result_o = ins;
            default:              result_o = word_i;
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({word_i, value_i, lsb_i, width_i, mode_i})) begin
         // R6
         err_passthru_chk: assert (!err_o || result_o == word_i)
            else $error("error case altered word");
         // R8
         pass_mode_chk: assert (mode_i != 2'd3 || result_o == word_i)
            else $error("pass-through mode altered word");
      end
   end
endmodule

// File: tb/bfu_field_unit_tb.sv
module bfu_field_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [31:0] word, value, result;
   logic [4:0]  lsb;
   logic [5:0]  width;
   logic [1:0]  mode;
   logic        err;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfu_field_unit u_dut (
      .word_i   (word),
      .value_i  (value),
      .lsb_i    (lsb),
      .width_i  (width),
      .mode_i   (mode),
      .result_o (result),
      .err_o    (err)
   );

   function automatic bit exp_err(int l, int w);
      return (w == 0) || (w > 32) || (l + w > 32);
   endfunction

   function automatic logic [31:0] exp_res(logic [31:0] wd, logic [31:0] v,
                                           int l, int w, int m);
      logic [31:0] r;
      if (exp_err(l, w) || m == 3) return wd;
      r = '0;
      if (m == 2) begin
         r = wd;
         for (int i = 0; i < w; i++) r[l+i] = v[i];
      end else begin
         for (int i = 0; i < 32; i++) begin
            if (i < w)       r[i] = wd[l+i];
            else if (m == 1) r[i] = wd[l+w-1];
            else             r[i] = 1'b0;
         end
      end
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (word=%h value=%h lsb=%0d width=%0d mode=%0d)",
                  tag, got, exp, word, value, lsb, width, mode);
      end
   endtask

   task automatic apply(logic [31:0] wd, logic [31:0] v, int l, int w, int m, string tag);
      @(posedge clk);
      word = wd; value = v; lsb = 5'(l); width = 6'(w); mode = 2'(m);
      @(negedge clk);
      check({tag, " result"}, result, exp_res(wd, v, l, w, m));
      check({tag, " err"}, {31'd0, err}, {31'd0, exp_err(l, w)});
   endtask

   initial begin
      word = '0; value = '0; lsb = '0; width = 6'd1; mode = '0;
      @(negedge clk);
      // reset-like idle state: 1-bit unsigned extract of zero
      check("R1 idle", result, 32'h0);
      check("R6 idle err", {31'd0, err}, 32'h0);

      // R1: bits 9..2, shifts 22 then 24
      apply(32'h0000_03FC, 0, 2, 8, 0, "R1 field 9..2");
      apply(32'hDEAD_BEEF, 0, 4, 12, 0, "R1 mid field");
      // R2: 16-bit -4 and positive field
      apply(32'h1234_FFFC, 0, 0, 16, 1, "R2 neg16");
      check("R2 literal", result, 32'hFFFF_FFFC);
      apply(32'h0000_0F00, 0, 8, 5, 1, "R2 positive");
      apply(32'h8000_0000, 0, 31, 1, 1, "R2 top bit");
      // R3 insert
      apply(32'h1234_5678, 32'h0000_00AB, 2, 8, 2, "R3 insert");
      // R4 high value bits ignored
      apply(32'h0000_0000, 32'hFFFF_FFF5, 4, 4, 2, "R4 high bits");
      check("R4 literal", result, 32'h0000_0050);
      // R5 mask keeps upper half
      apply(32'hFFFF_FFFF, 32'h0, 2, 8, 2, "R5 mask");
      check("R5 literal", result, 32'hFFFF_FC03);
      // R6 errors
      apply(32'hCAFE_F00D, 32'h1, 30, 4, 2, "R6 overrun");
      apply(32'hCAFE_F00D, 32'h1, 0, 0, 0, "R6 zero width");
      apply(32'hCAFE_F00D, 32'h1, 0, 40, 1, "R6 too wide");
      // R7 full width
      apply(32'hA5A5_5A5A, 32'h1357_9BDF, 0, 32, 0, "R7 extract full");
      apply(32'hA5A5_5A5A, 32'h1357_9BDF, 0, 32, 2, "R7 insert full");
      check("R7 literal", result, 32'h1357_9BDF);
      // R8 pass-through
      apply(32'h0BAD_CAFE, 32'hFFFF_FFFF, 3, 7, 3, "R8 pass");

      void'($urandom(32'd2024));
      for (int n = 0; n < 400; n++) begin
         int l, w, m;
         l = int'($urandom_range(0, 31));
         w = int'($urandom_range(1, 32 - l));
         if ($urandom_range(0, 9) == 0) w = int'($urandom_range(0, 63));
         m = int'($urandom_range(0, 3));
         apply($urandom, $urandom, l, w, m, "R1 R2 R3 R6 random");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule